// File: doc/BRIEF.md
# Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 512-byte two-wire serial memory. It takes oversampled SCL and SDA levels and resynchronizes them to the system clock. From them it derives SCL edges, START, repeated START and STOP. SDA is driven only through an open-drain pull-down enable. The engine decodes the device select byte against two strap inputs and collects a word address. Each received data byte is handed to the write controller as a one-cycle strobe with address and data, and is written into an internal synchronous 512x8 array.

Reads come in three forms. A current-address read uses the internal pointer as it stands. A random read sends a write-direction select and a word address, then a repeated START and a read-direction select. A sequential read runs for as long as the master keeps acknowledging. The ninth address bit travels in the device select byte, so one slave covers the whole array with only two strap bits.

Top module: `serial_mem_slave`

## Requirements
- R1: A select byte is accepted only when its bits 7..4 are 1010, bit 3 equals `ce_hi` and bit 2 equals `ce_lo`, with bit 0 as direction (1 = read). Any other select byte gets no acknowledge, and the engine stays silent until the next START or STOP.
- R2: After each accepted byte in the write direction (select, word address, data), the slave holds SDA low through the ninth SCL pulse. It releases SDA after that pulse falls.
- R3: In the write direction, the byte that follows the select byte loads the pointer. The low 8 bits come from that byte and bit 8 comes from bit 1 of the select byte.
- R4: Each data byte that follows the word address is stored at the pointer and shown on `wr_stb`/`wr_addr`/`wr_data` for one cycle. The pointer then steps by one, wrapping from 511 to 0.
- R5: A read-direction select is followed by the byte at the pointer, MSB first. A 0 bit is sent by driving SDA low.
- R6: A repeated START after the word address, followed by a read-direction select, returns the byte at the loaded address.
- R7: The pointer steps after every byte read, wrapping from 511 to 0. A master acknowledge (SDA low in the ninth bit) starts the next byte.
- R8: A master NACK after a read byte ends the read. The slave releases SDA and drives nothing until a new START.
- R9: A START inside a byte restarts select reception. A STOP inside a byte returns to idle without changing the pointer.
- R10: While `rst` is high the slave ignores the bus, never drives SDA and clears the pointer to 0.
- R11: The SDA drive enable rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Active-high power-on reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| ce_hi | input | 1 | Strap compared with select bit 3 |
| ce_lo | input | 1 | Strap compared with select bit 2 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wr_stb | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | ADDR_W | Address of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |

## Verification
The hardest states to reach are those where the master gives up partway through a byte. Two examples are a START after only three select bits and a STOP after four address bits. The bench reaches them with bit-level tasks that clock single bits and then issue a condition. It then proves through later reads that the pointer was or was not touched. The pointer wrap is reached by a burst write that crosses address 511, followed by a sequential read over the same boundary. The read-side NACK release is checked by clocking extra SCL pulses after the NACK and watching that SDA stays high.

// File: rtl/smem_pkg.sv
package smem_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK,
      ST_WAIT
   } bus_st_t;

   localparam logic [3:0] SEL_CODE = 4'b1010;
endpackage

// File: rtl/smem_bus_sync.sv
module smem_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("smem_bus_sync: STAGES must be 2 or more");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_s;
         sda_q    <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] cnt
);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (inc)
         cnt <= cnt + 1'b1;
   end

   // R7: stepping past the last location lands on zero
   a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
      (inc && !load && cnt == TOP) |=> (cnt == '0));

   // R3: a load takes the presented address
   a_r3_ptr_load: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/smem_array.sv
module smem_array #(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
   import smem_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              ce_hi,
   input  logic              ce_lo,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   localparam int              BYTE_W   = 8;
   localparam int              CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (ADDR_W != 8 && ADDR_W != 9) begin : g_bad_aw
      $error("serial_mem_slave: ADDR_W must be 8 or 9");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   smem_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   bus_st_t           st;
   logic [CNT_W-1:0]  bcnt;
   logic [BYTE_W-1:0] sh;
   logic              rw_q;
   logic              a8_q;
   logic              m_ack;
   logic              oe_q;
   logic              no_cond;
   logic              byte_done;
   logic              dev_match;
   logic              ctr_load;
   logic              ctr_inc;
   logic              mem_we;
   logic [ADDR_W-1:0] ctr_val;
   logic [ADDR_W-1:0] ptr;
   logic [BYTE_W-1:0] rdata;

   assign no_cond   = ~start_det & ~stop_det;
   assign byte_done = scl_fall & (bcnt == LAST_BIT) & no_cond;
   assign dev_match = (sh[7:4] == SEL_CODE) & (sh[3] == ce_hi) & (sh[2] == ce_lo);
   assign mem_we    = (st == ST_WDATA) & byte_done;
   assign ctr_load  = (st == ST_ADDR) & byte_done;
   assign ctr_inc   = mem_we | ((st == ST_RDATA) & byte_done);

   if (ADDR_W == 9) begin : g_hi_bit
      assign ctr_val = {a8_q, sh};
   end else begin : g_no_hi_bit
      assign ctr_val = sh;
   end

   smem_addr_ctr #(.AW(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load     (ctr_load),
      .load_val (ctr_val),
      .inc      (ctr_inc),
      .cnt      (ptr)
   );

   smem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (ptr),
      .wdata (sh),
      .raddr (ptr),
      .rdata (rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= ST_IDLE;
         bcnt  <= '0;
         sh    <= '0;
         rw_q  <= 1'b0;
         a8_q  <= 1'b0;
         m_ack <= 1'b0;
         oe_q  <= 1'b0;
      end else if (start_det) begin
         st   <= ST_DEV;
         bcnt <= '0;
         oe_q <= 1'b0;
      end else if (stop_det) begin
         st   <= ST_IDLE;
         bcnt <= '0;
         oe_q <= 1'b0;
      end else begin
         unique case (st)
            ST_DEV, ST_ADDR, ST_WDATA: begin
               if (scl_rise && bcnt < LAST_BIT) begin
                  sh   <= {sh[BYTE_W-2:0], sda_s};
                  bcnt <= bcnt + 1'b1;
               end else if (byte_done) begin
                  if (st == ST_DEV) begin
                     if (dev_match) begin
                        rw_q <= sh[0];
                        a8_q <= sh[1];
                        oe_q <= 1'b1;
                        st   <= ST_DEV_ACK;
                     end else begin
                        st <= ST_WAIT;
                     end
                  end else if (st == ST_ADDR) begin
                     oe_q <= 1'b1;
                     st   <= ST_ADDR_ACK;
                  end else begin
                     oe_q <= 1'b1;
                     st   <= ST_WDATA_ACK;
                  end
               end
            end
            ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: begin
               if (scl_fall) begin
                  bcnt <= '0;
                  oe_q <= 1'b0;
                  if (st == ST_DEV_ACK && rw_q) begin
                     sh   <= rdata;
                     oe_q <= ~rdata[BYTE_W-1];
                     bcnt <= CNT_W'(1);
                     st   <= ST_RDATA;
                  end else if (st == ST_DEV_ACK) begin
                     st <= ST_ADDR;
                  end else begin
                     st <= ST_WDATA;
                  end
               end
            end
            ST_RDATA: begin
               if (byte_done) begin
                  oe_q <= 1'b0;
                  bcnt <= '0;
                  st   <= ST_RDATA_ACK;
               end else if (scl_fall) begin
                  sh   <= {sh[BYTE_W-2:0], 1'b0};
                  oe_q <= ~sh[BYTE_W-2];
                  bcnt <= bcnt + 1'b1;
               end
            end
            ST_RDATA_ACK: begin
               if (scl_rise) begin
                  m_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (m_ack) begin
                     sh   <= rdata;
                     oe_q <= ~rdata[BYTE_W-1];
                     bcnt <= CNT_W'(1);
                     st   <= ST_RDATA;
                  end else begin
                     st <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe  = oe_q;
   assign wr_stb  = mem_we;
   assign wr_addr = ptr;
   assign wr_data = sh;

   // R10: reset keeps the line released
   a_r10_reset_quiet: assert property (@(posedge clk)
      rst |=> !sda_oe);

   // R9: a STOP releases SDA and parks the engine
   a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
      stop_det |=> (!sda_oe && st == ST_IDLE));

   // R11: drive enable turns on only with SCL low
   a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
      $rose(sda_oe) |-> !scl_s);

   // R1: a foreign select byte leaves the slave silent
   a_r1_foreign_select: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DEV && byte_done && !dev_match) |=> (st == ST_WAIT && !sda_oe));

   // R8: a NACK after a read byte releases the line
   a_r8_nack_release: assert property (@(posedge clk) disable iff (rst)
      (st == ST_RDATA_ACK && scl_fall && !m_ack && no_cond) |=> (!sda_oe && st == ST_WAIT));
endmodule

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       ce_hi = 1'b1;
   logic       ce_lo = 1'b0;
   logic       sda_bus;
   logic       sda_oe;
   logic       wr_stb;
   logic [8:0] wr_addr;
   logic [7:0] wr_data;

   int tests = 0;
   int fails = 0;
   int wr_seen = 0;
   int viol = 0;
   int oe_in_rst = 0;
   bit done = 1'b0;
   logic       oe_prev = 1'b0;
   logic [8:0] last_wa = '0;
   logic [7:0] last_wd = '0;
   logic [7:0] ref_mem [512];
   int         ptr_m = 0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   serial_mem_slave u0 (
      .clk     (clk),
      .rst     (rst),
      .scl_i   (scl_m),
      .sda_i   (sda_bus),
      .ce_hi   (ce_hi),
      .ce_lo   (ce_lo),
      .sda_oe  (sda_oe),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         wr_seen++;
         last_wa = wr_addr;
         last_wd = wr_data;
      end
      if (sda_oe && !oe_prev && scl_m) viol++;
      if (rst && sda_oe) oe_in_rst++;
      oe_prev = sda_oe;
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_tx(input logic b);
      tick(4); sda_m = b; tick(4); scl_m = 1'b1; tick(8); scl_m = 1'b0;
   endtask

   task automatic bit_rx(output logic b);
      sda_m = 1'b1; tick(8); scl_m = 1'b1; tick(4); b = sda_bus; tick(4); scl_m = 1'b0;
   endtask

   task automatic start_c();
      if (scl_m == 1'b0) begin
         tick(2); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
      end
      sda_m = 1'b0; tick(8); scl_m = 1'b0;
   endtask

   task automatic stop_c();
      tick(6); sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8); sda_m = 1'b1; tick(8);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) bit_tx(b[i]);
      bit_rx(x);
      ack = ~x;
   endtask

   task automatic read_byte(input logic ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) bit_rx(d[i]);
      bit_tx(~ack);
   endtask

   function automatic logic [7:0] dsel(input logic a8, input logic rw);
      return {4'hA, 1'b1, 1'b0, a8, rw};
   endfunction

   task automatic rand_read(input int a, output logic [7:0] d);
      logic ack;
      logic [8:0] av;
      av = a[8:0];
      start_c();
      send_byte(dsel(av[8], 1'b0), ack);
      send_byte(av[7:0], ack);
      start_c();
      send_byte(dsel(1'b0, 1'b1), ack);
      chk("R6 read select ack", int'(ack), 1);
      read_byte(1'b0, d);
      stop_c();
      ptr_m = (a + 1) % 512;
   endtask

   initial begin
      logic       ack;
      logic [7:0] d;
      logic [8:0] av;
      logic       b;
      int         ones;

      // R10: traffic during reset
      tick(5);
      start_c();
      send_byte(dsel(1'b0, 1'b0), ack);
      chk("R10 no ack in reset", int'(ack), 0);
      stop_c();
      chk("R10 line never driven in reset", oe_in_rst, 0);
      chk("R10 sda released", int'(sda_oe), 0);
      rst = 1'b0;
      tick(5);

      // R1: strap sweep plus a wrong family code
      for (int e = 0; e < 4; e++) begin
         logic [1:0] ev;
         ev = e[1:0];
         start_c();
         send_byte({4'hA, ev, 2'b00}, ack);
         chk("R1 strap match", int'(ack), (ev == 2'b10) ? 1 : 0);
         stop_c();
      end
      start_c();
      send_byte({4'hB, 2'b10, 2'b00}, ack);
      chk("R1 wrong code", int'(ack), 0);
      stop_c();

      // R2 R3 R4: single writes over a spread of addresses
      for (int k = 0; k < 8; k++) begin
         int a;
         logic [7:0] dv;
         a  = (k * 67 + 3) % 512;
         dv = 8'((k * 29 + 17) & 255);
         av = a[8:0];
         start_c();
         send_byte(dsel(av[8], 1'b0), ack);
         chk("R2 select ack", int'(ack), 1);
         send_byte(av[7:0], ack);
         chk("R2 address ack", int'(ack), 1);
         send_byte(dv, ack);
         chk("R2 data ack", int'(ack), 1);
         chk("R4 strobe address", int'(last_wa), a);
         chk("R4 strobe data", int'(last_wd), int'(dv));
         stop_c();
         ref_mem[a] = dv;
      end
      chk("R4 strobe count", wr_seen, 8);

      // R4: burst write over the top of the array
      start_c();
      send_byte(dsel(1'b1, 1'b0), ack);
      send_byte(8'hFD, ack);
      for (int j = 0; j < 5; j++) begin
         int a;
         a = (509 + j) % 512;
         send_byte(8'hA0 + 8'(j), ack);
         chk("R4 burst address", int'(last_wa), a);
         ref_mem[a] = 8'hA0 + 8'(j);
      end
      stop_c();
      ptr_m = 2;

      // R3 R6: random reads of every written location
      for (int k = 0; k < 8; k++) begin
         int a;
         a = (k * 67 + 3) % 512;
         rand_read(a, d);
         chk("R3 R6 random read", int'(d), int'(ref_mem[a]));
      end

      // R7: sequential read crossing 511 to 0
      rand_read(509, d);
      chk("R7 first", int'(d), int'(ref_mem[509]));
      start_c();
      send_byte(dsel(1'b0, 1'b1), ack);
      for (int j = 0; j < 3; j++) begin
         int a;
         a = (510 + j) % 512;
         read_byte(j < 2, d);
         chk("R7 sequential", int'(d), int'(ref_mem[a]));
      end
      ptr_m = 1;

      // R8: after the NACK the slave stays off the line
      ones = 0;
      for (int j = 0; j < 9; j++) begin
         bit_rx(b);
         ones += int'(b);
      end
      chk("R8 released after nack", ones, 9);
      stop_c();

      // R5: current-address read from the pointer
      start_c();
      send_byte(dsel(1'b0, 1'b1), ack);
      chk("R5 select ack", int'(ack), 1);
      read_byte(1'b0, d);
      chk("R5 current read", int'(d), int'(ref_mem[1]));
      stop_c();
      ptr_m = 2;

      // R9: START after three select bits, then a random read
      start_c();
      bit_tx(1'b1); bit_tx(1'b0); bit_tx(1'b1);
      start_c();
      send_byte(dsel(1'b1, 1'b0), ack);
      chk("R9 select after abort", int'(ack), 1);
      send_byte(8'hFD, ack);
      start_c();
      send_byte(dsel(1'b0, 1'b1), ack);
      read_byte(1'b0, d);
      chk("R9 read after abort", int'(d), int'(ref_mem[509]));
      stop_c();
      ptr_m = 510;

      // R9: STOP after four address bits keeps the pointer
      start_c();
      send_byte(dsel(1'b0, 1'b0), ack);
      bit_tx(1'b0); bit_tx(1'b0); bit_tx(1'b0); bit_tx(1'b0);
      stop_c();
      start_c();
      send_byte(dsel(1'b0, 1'b1), ack);
      read_byte(1'b0, d);
      chk("R9 pointer kept after stop", int'(d), int'(ref_mem[ptr_m]));
      stop_c();

      // R11: drive enable only rose with SCL low
      chk("R11 oe rise while scl low", viol, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule